// File: doc/BRIEF.md
# Hysteretic Binary Input Detector with Debounce

The block watches a stream of 8-bit unsigned ADC codes from one sensed input and turns it into a clean logic level. The level rises once the samples have stayed at or above an upper code for a programmable qualification time. It falls once they have stayed at or below a lower code for that same time. Samples between the two codes do not change the level, so the gap between the codes sets the hysteresis. If both codes are equal, the comparison uses a single level.

Qualification time is counted in ticks of an external strobe, nominally one every 20 µs. A count of 150 gives 3 ms and a count of 250 gives 5 ms. The filter word also carries a channel enable. While that enable is clear, the output is forced low and the qualification state is wiped. Software reaches the two 16-bit configuration words through a one-bit select, a write strobe and a combinational read path. Several instances can serve a main channel and any number of warning channels, each with its own reset constants.

Top module: `bid_detector`

## Requirements
- R1: After reset the output is low, the threshold word holds THR_INIT (default 0xAA5A), and the filter word holds FILT_INIT (default 0x0096, channel disabled).
- R2: With `reg_we` high, `reg_sel`=0 writes the threshold word and `reg_sel`=1 writes the filter word at the clock edge. `reg_rdata` always shows the word picked by `reg_sel`.
- R3: The threshold word has the upper code in bits [15:8] and the lower code in bits [7:0]. A valid sample is high-qualifying when it is greater than or equal to the upper code. From a low output, one such sample starts a run. The output rises on the clock edge after the run has counted the filter count of ticks.
- R4: A valid sample is low-qualifying when it is less than or equal to the lower code. From a high output, such a sample starts a run, and the output falls under the same tick rule as in R3.
- R5: A valid sample that does not qualify for the pending transition ends the run and zeroes the count. A later transition then needs a fresh qualifying sample and a full count.
- R6: Samples strictly between the lower and upper codes never change the output, however many ticks pass.
- R7: If the upper and lower codes are equal, that one code both raises a low output and drops a high output.
- R8: Filter bit 15 is the channel enable. While it is clear, the output is low one cycle later and the run and count are cleared, so a run cut short by disabling does not resume.
- R9: The qualification count advances only in cycles with `tick` high. Without ticks, a pending run never completes.
- R10: Filter bits [14:0] hold the count. A count of zero makes the output toggle on the clock edge after the first qualifying sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Qualification time strobe, one cycle wide |
| smp_vld | input | 1 | Sample present on `smp_code` this cycle |
| smp_code | input | 8 | Unsigned ADC code |
| reg_sel | input | 1 | Word select: 0 threshold, 1 filter |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Selected word |
| level_out | output | 1 | Debounced input level |

## Verification
The hardest case to reach from the ports is showing that disabling the channel really wipes a partly counted run. A leftover count only becomes visible if the channel is re-enabled and the run is then driven to an edge that would complete only with the stale count. The stimulus builds a run to three of four ticks and clears and sets the enable bit with two register writes. It then supplies one qualifying sample plus a single tick and checks that the output stays low. The same off-by-one timing is used for R3 and R4: the output is checked on the cycle before the expected transition as well as on the cycle of it.

// File: rtl/bid_pkg.sv
// Package: shared widths and packed layouts of the two configuration words.
// Assumes 16-bit words and 8-bit sample codes.
package bid_pkg;
    localparam int WORD_W = 16;
    localparam int SMP_W  = 8;
    localparam int CNT_W  = WORD_W - 1;

    // Threshold word: upper code in the high byte, lower code in the low byte.
    typedef struct packed {
        logic [SMP_W-1:0] upper;
        logic [SMP_W-1:0] lower;
    } thr_word_t;

    // Filter word: enable in the top bit, tick count below it.
    typedef struct packed {
        logic             en;
        logic [CNT_W-1:0] count;
    } filt_word_t;
endpackage

// File: rtl/bid_regfile.sv
// Module: holds the threshold and filter words behind a one-bit select.
// Assumes writes take effect at the clock edge and reads are combinational.
module bid_regfile
    import bid_pkg::*;
#(
    parameter logic [WORD_W-1:0] THR_INIT  = 16'hAA5A,
    parameter logic [WORD_W-1:0] FILT_INIT = 16'h0096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output thr_word_t         thr,
    output filt_word_t        filt
);
    thr_word_t  thr_q;
    filt_word_t filt_q;

    // Store the written word in the selected register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q  <= thr_word_t'(THR_INIT);
            filt_q <= filt_word_t'(FILT_INIT);
        end else if (we) begin
            if (sel) filt_q <= filt_word_t'(wdata);
            else     thr_q  <= thr_word_t'(wdata);
        end
    end

    // Return the selected word.
    always_comb begin
        rdata = sel ? WORD_W'(filt_q) : WORD_W'(thr_q);
    end

    assign thr  = thr_q;
    assign filt = filt_q;
endmodule

// File: rtl/bid_classify.sv
// Module: sorts a sample against the codes for the transition now pending.
// Assumes level_now is the registered output; with no valid sample both
// flags are low.
module bid_classify
    import bid_pkg::*;
(
    input  logic             vld,
    input  logic [SMP_W-1:0] code,
    input  logic [SMP_W-1:0] upper,
    input  logic [SMP_W-1:0] lower,
    input  logic             level_now,
    output logic             qual,
    output logic             brk
);
    logic at_or_above;
    logic at_or_below;

    // Compare the sample with each threshold code.
    always_comb begin
        at_or_above = (code >= upper);
        at_or_below = (code <= lower);
    end

    // Pick the condition matching the transition the output waits for.
    always_comb begin
        if (level_now) begin
            qual = vld && at_or_below;
            brk  = vld && !at_or_below;
        end else begin
            qual = vld && at_or_above;
            brk  = vld && !at_or_above;
        end
    end
endmodule

// File: rtl/bid_qualifier.sv
// Module: run flag, tick counter and output flop for the debounce.
// Assumes tick is a one-cycle strobe and that qual and brk never both hold.
module bid_qualifier
    import bid_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             qual,
    input  logic             brk,
    input  logic [CNT_W-1:0] limit,
    output logic             level,
    output logic             run,
    output logic [CNT_W-1:0] cnt
);
    logic             level_q;
    logic             run_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done;

    // A run completes once its count has reached the programmed limit.
    always_comb begin
        done = run_q && (cnt_q >= limit);
    end

    // Advance the run, restart it, or flip the output once it completes.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            level_q <= 1'b0;
            run_q   <= 1'b0;
            cnt_q   <= '0;
        end else if (brk) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (done) begin
            level_q <= !level_q;
            run_q   <= 1'b0;
            cnt_q   <= '0;
        end else begin
            if (qual)          run_q <= 1'b1;
            if (run_q && tick) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign level = level_q;
    assign run   = run_q;
    assign cnt   = cnt_q;
endmodule

// File: rtl/bid_detector.sv
// Module: top of the hysteretic binary input detector.
// Assumes one sample per cycle at most and an external time tick.
module bid_detector
    import bid_pkg::*;
#(
    parameter logic [WORD_W-1:0] THR_INIT  = 16'hAA5A,
    parameter logic [WORD_W-1:0] FILT_INIT = 16'h0096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              smp_vld,
    input  logic [SMP_W-1:0]  smp_code,
    input  logic              reg_sel,
    input  logic              reg_we,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              level_out
);
    thr_word_t        thr_w;
    filt_word_t       filt_w;
    logic             qual_w;
    logic             brk_w;
    logic             run_w;
    logic [CNT_W-1:0] cnt_w;
    logic             en_w;
    logic [CNT_W-1:0] limit_w;

    assign en_w    = filt_w.en;
    assign limit_w = filt_w.count;

    bid_regfile #(.THR_INIT(THR_INIT), .FILT_INIT(FILT_INIT)) u_regs (
        .clk(clk), .rst_n(rst_n), .sel(reg_sel), .we(reg_we),
        .wdata(reg_wdata), .rdata(reg_rdata), .thr(thr_w), .filt(filt_w)
    );

    bid_classify u_cls (
        .vld(smp_vld), .code(smp_code), .upper(thr_w.upper),
        .lower(thr_w.lower), .level_now(level_out),
        .qual(qual_w), .brk(brk_w)
    );

    bid_qualifier u_qual (
        .clk(clk), .rst_n(rst_n), .en(en_w), .tick(tick),
        .qual(qual_w), .brk(brk_w), .limit(limit_w),
        .level(level_out), .run(run_w), .cnt(cnt_w)
    );
endmodule

// File: rtl/bid_detector_chk.sv
// Module: temporal checks on the detector, attached by bind.
module bid_detector_chk
    import bid_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             en,
    input logic             brk,
    input logic             run,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] limit,
    input logic             level_out
);
    // R8
    off_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !level_out);

    // R9
    count_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> (cnt == $past(cnt)) || (cnt == '0));

    // R5
    break_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && brk) |=> (cnt == '0) && !run);

    // R3
    flip_after_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && (level_out != $past(level_out)))
            |-> ($past(run) && ($past(cnt) >= $past(limit))));

    // R8
    off_clears_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !run && (cnt == '0));
endmodule

bind bid_detector bid_detector_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(en_w), .brk(brk_w),
    .run(run_w), .cnt(cnt_w), .limit(limit_w), .level_out(level_out)
);

// File: tb/sim_bid_detector.sv
`timescale 1ns/1ps
module sim_bid_detector;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        smp_vld = 1'b0;
    logic [7:0]  smp_code = 8'h00;
    logic        reg_sel = 1'b0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = 16'h0000;
    logic [15:0] reg_rdata;
    logic        level_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        bit          is_reg;
        logic [15:0] exp;
        string       tag;
    } sb_item_t;
    sb_item_t sb_q[$];
    sb_item_t cur;

    always #2.5 clk = !clk;

    bid_detector u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .smp_vld(smp_vld),
        .smp_code(smp_code), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .level_out(level_out)
    );

    // Monitor: pop expected items and compare at the falling edge.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            cur = sb_q.pop_front();
            checks++;
            if (cur.is_reg && reg_rdata !== cur.exp) begin
                errors++;
                $display("FAIL %s rdata actual=%h expected=%h", cur.tag, reg_rdata, cur.exp);
            end else if (!cur.is_reg && level_out !== cur.exp[0]) begin
                errors++;
                $display("FAIL %s level actual=%b expected=%b", cur.tag, level_out, cur.exp[0]);
            end
        end
    end

    // Drive one cycle of inputs, return just after the capturing edge.
    task automatic cyc(input bit v, input logic [7:0] c, input bit t);
        smp_vld = v; smp_code = c; tick = t;
        @(posedge clk); #1;
        smp_vld = 1'b0; tick = 1'b0;
    endtask

    task automatic wr(input bit s, input logic [15:0] d);
        reg_sel = s; reg_we = 1'b1; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic exp_level(input bit e, input string tag);
        sb_item_t it;
        it.is_reg = 1'b0; it.exp = {15'b0, e}; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic exp_reg(input bit s, input logic [15:0] e, input string tag);
        sb_item_t it;
        reg_sel = s;
        it.is_reg = 1'b1; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk); #1;
    endtask

    // Qualifying sample followed by n ticks carrying code c.
    task automatic run_ticks(input logic [7:0] q, input logic [7:0] c, input int n);
        cyc(1'b1, q, 1'b0);
        for (int i = 0; i < n; i++) cyc(1'b1, c, 1'b1);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        cyc(1'b0, 8'h00, 1'b0);
        // R1 reset state
        exp_level(1'b0, "R1");
        exp_reg(1'b0, 16'hAA5A, "R1");
        exp_reg(1'b1, 16'h0096, "R1");
        // R8 disabled by default: high samples with ticks do nothing
        for (int i = 0; i < 200; i++) cyc(1'b1, 8'hFF, 1'b1);
        exp_level(1'b0, "R8");
        // R2 write and read back; filter count 4, enabled
        wr(1'b1, 16'h8004);
        exp_reg(1'b1, 16'h8004, "R2");
        wr(1'b0, 16'hAA5A);
        exp_reg(1'b0, 16'hAA5A, "R2");
        // R3 rise: code equal to upper qualifies
        run_ticks(8'hAA, 8'hC0, 4);
        exp_level(1'b0, "R3");
        cyc(1'b0, 8'h00, 1'b0);
        exp_level(1'b1, "R3");
        // R6 mid-band samples keep the level
        for (int i = 0; i < 10; i++) cyc(1'b1, 8'h80, 1'b1);
        exp_level(1'b1, "R6");
        // R4 fall
        run_ticks(8'h5A, 8'h10, 4);
        exp_level(1'b1, "R4");
        cyc(1'b0, 8'h00, 1'b0);
        exp_level(1'b0, "R4");
        for (int i = 0; i < 10; i++) cyc(1'b1, 8'h80, 1'b1);
        exp_level(1'b0, "R6");
        // R5 break restarts count
        run_ticks(8'hAA, 8'hC0, 3);
        cyc(1'b1, 8'hA9, 1'b0);
        for (int i = 0; i < 4; i++) cyc(1'b0, 8'h00, 1'b1);
        cyc(1'b0, 8'h00, 1'b0);
        exp_level(1'b0, "R5");
        run_ticks(8'hAA, 8'hC0, 4);
        cyc(1'b0, 8'h00, 1'b0);
        exp_level(1'b1, "R5");
        run_ticks(8'h5A, 8'h10, 4);
        cyc(1'b0, 8'h00, 1'b0);
        exp_level(1'b0, "R4");
        // R9 no ticks, no completion
        cyc(1'b1, 8'hF0, 1'b0);
        for (int i = 0; i < 20; i++) cyc(1'b1, 8'hF0, 1'b0);
        exp_level(1'b0, "R9");
        cyc(1'b1, 8'h00, 1'b0);
        // R7 single level
        wr(1'b0, 16'hCCCC);
        run_ticks(8'hCC, 8'hCC, 4);
        cyc(1'b0, 8'h00, 1'b0);
        exp_level(1'b1, "R7");
        run_ticks(8'hCC, 8'hCB, 4);
        cyc(1'b0, 8'h00, 1'b0);
        exp_level(1'b0, "R7");
        // R10 zero count
        wr(1'b1, 16'h8000);
        cyc(1'b1, 8'hCC, 1'b0);
        exp_level(1'b0, "R10");
        cyc(1'b0, 8'h00, 1'b0);
        exp_level(1'b1, "R10");
        // R8 disable forces low one cycle later
        wr(1'b1, 16'h0004);
        exp_level(1'b1, "R8");
        cyc(1'b0, 8'h00, 1'b0);
        exp_level(1'b0, "R8");
        // R8 partial run is wiped by disable
        wr(1'b1, 16'h8004);
        run_ticks(8'hFF, 8'hFF, 3);
        wr(1'b1, 16'h0004);
        wr(1'b1, 16'h8004);
        cyc(1'b1, 8'hFF, 1'b1);
        cyc(1'b0, 8'h00, 1'b0);
        exp_level(1'b0, "R8");
        for (int i = 0; i < 4; i++) cyc(1'b0, 8'h00, 1'b1);
        cyc(1'b0, 8'h00, 1'b0);
        exp_level(1'b1, "R8");
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule